// File: doc/BRIEF.md
# Compare/Capture Timer Channel

This block is one channel of an up-counting timer. It holds a counter and two constant registers, A and B, of the same width. The counter advances by one on each cycle in which the count-enable strobe is high. Register A is always a compare register. When the counter steps onto the value in A, a flag is raised and a selectable action is applied to the timer output pin.

Register B has two roles, and one control bit chooses between them. In compare mode it behaves like A, with its own output action. In capture mode it latches the counter whenever a chosen edge appears on the synchronised capture input. In that mode the same two control bits select the capture edge instead of an output action.

Three sticky status flags report a match on A, a match or capture on B, and counter wrap-around. Software can clear a flag only by first reading it as 1 and then writing 0 to it. Software reaches the counter, the two constant registers and the control/status register through a simple synchronous port with a 2-bit offset.

Top module: `cmpcap_timer`

## Requirements
- R1: After reset the counter, both constant registers and the control/status register read 0, all three flags are 0 and the timer output is 0.
- R2: Offsets are: 0 counter, 1 register A, 2 register B, 3 control/status. The counter increments only in a cycle with `cnt_en` high. A write to offset 0 loads the counter, takes priority over an increment and produces no match or wrap event in that cycle.
- R3: Control/status layout: bit 7 flag B, bit 6 flag A, bit 5 wrap flag, bit 4 capture enable, bits 3:2 B select, bits 1:0 A select. The wrap flag sets on the step from all-ones to 0.
- R4: When a step makes the counter equal to A, flag A sets and A select acts on the output: 00 holds, 01 drives 0, 10 drives 1, 11 toggles. The output changes on the same clock edge as the counter.
- R5: With capture enable 0, a step onto the value in B sets flag B and applies B select with the same encoding as R4. When A and B match on the same step, only A's action is applied.
- R6: With capture enable 1, `cap_in` passes through a two-stage synchroniser. B select 00 picks rising edges, 01 falling edges and 1x both edges. On a picked edge the counter is copied into B and flag B sets, three clock edges after the input changes.
- R7: With capture enable 1, writes to register B are ignored, and a counter match on B changes neither the output nor flag B.
- R8: A flag clears only when 0 is written to its bit after a read of offset 3 that returned it as 1. Writing 1, or writing 0 without such a read, leaves it set. A set event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-enable strobe |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clears) |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, combinational from offset |
| cap_in | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | Timer output pin |
| flag_ovf | output | 1 | Wrap flag |
| flag_a | output | 1 | Compare A flag |
| flag_b | output | 1 | Compare/capture B flag |

## Verification
The bench goes after the flag-clearing handshake. A write of 0 made before any read must leave a flag set, and a design that cleared on any 0 write would lose it. A run where A and B match on the same step shows whether the output takes A's action; a design that let B win would end with the opposite level. In capture mode the bench also steps the counter onto B's value with a "drive high" pattern in the select bits, which catches a design that still applies compare-B actions. It then checks that capture fires on the selected edge and not on the other one, and that it stores the counter value.

// File: rtl/cmpcap_pkg.sv
package cmpcap_pkg;

  localparam logic [1:0] OFF_CNT = 2'd0;
  localparam logic [1:0] OFF_A   = 2'd1;
  localparam logic [1:0] OFF_B   = 2'd2;
  localparam logic [1:0] OFF_CSR = 2'd3;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } out_act_e;

  // Next output level for a given action code.
  function automatic logic act_apply(input logic cur, input logic [1:0] sel);
    case (out_act_e'(sel))
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_TOG:  return ~cur;
      default:  return cur;
    endcase
  endfunction

  // Whether a detected edge matches the capture-edge selection.
  function automatic logic edge_pick(input logic [1:0] sel, input logic rise,
                                     input logic fall);
    if (sel[1]) return rise | fall;
    if (sel[0]) return fall;
    return rise;
  endfunction

endpackage

// File: rtl/cmpcap_counter.sv
module cmpcap_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         step_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAXV = '1;

  assign step_o = inc_i && !ld_i;
  assign nxt_o  = cnt_o + 1'b1;
  assign wrap_o = step_o && (cnt_o == MAXV);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (ld_i)   cnt_o <= ld_val_i;
    else if (inc_i)  cnt_o <= nxt_o;
  end
endmodule

// File: rtl/cmpcap_edge.sv
module cmpcap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= async_i;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign rise_o =  chain[STAGES-1] && !last;
  assign fall_o = !chain[STAGES-1] &&  last;
endmodule

// File: rtl/cmpcap_flag.sv
module cmpcap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr0_i,
  output logic flag_o,
  output logic arm_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      arm_o  <= 1'b0;
    end else begin
      if (set_i)               flag_o <= 1'b1;
      else if (wr0_i && arm_o) flag_o <= 1'b0;
      if (wr0_i)               arm_o  <= 1'b0;
      if (rd_i && flag_o)      arm_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/cmpcap_timer.sv
module cmpcap_timer
  import cmpcap_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         cap_in,
  output logic         tmr_out,
  output logic         flag_ovf,
  output logic         flag_a,
  output logic         flag_b
);
  localparam int NFLAG = 3;   // index 0 wrap, 1 A, 2 B
  localparam int FBASE = 5;   // flags occupy csr bits 7:5

  logic [W-1:0]     cnt, nxt, reg_a, reg_b;
  logic [4:0]       ctl;
  logic             step, evt_ovf, evt_a, evt_b, evt_cap;
  logic             rise, fall, ice;
  logic [1:0]       sel_a, sel_b;
  logic [NFLAG-1:0] flag_q, arm_q, set_v, wr0_v;
  logic             csr_wr, csr_rd;

  assign ice   = ctl[4];
  assign sel_b = ctl[3:2];
  assign sel_a = ctl[1:0];

  cmpcap_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(cnt_en),
    .ld_i(bus_wr && bus_addr == OFF_CNT), .ld_val_i(bus_wdata),
    .cnt_o(cnt), .nxt_o(nxt), .step_o(step), .wrap_o(evt_ovf)
  );

  cmpcap_edge #(.STAGES(STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .async_i(cap_in), .rise_o(rise), .fall_o(fall)
  );

  assign evt_a   = step && (nxt == reg_a);
  assign evt_b   = step && !ice && (nxt == reg_b);
  assign evt_cap = ice && edge_pick(sel_b, rise, fall);

  assign csr_wr = bus_wr && bus_addr == OFF_CSR;
  assign csr_rd = bus_rd && bus_addr == OFF_CSR;
  assign set_v  = {evt_b || evt_cap, evt_a, evt_ovf};

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      assign wr0_v[i] = csr_wr && !bus_wdata[FBASE+i];
      cmpcap_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(set_v[i]), .rd_i(csr_rd),
        .wr0_i(wr0_v[i]), .flag_o(flag_q[i]), .arm_o(arm_q[i])
      );
    end
  endgenerate

  assign flag_ovf = flag_q[0];
  assign flag_a   = flag_q[1];
  assign flag_b   = flag_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a   <= '0;
      reg_b   <= '0;
      ctl     <= '0;
      tmr_out <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFF_A) reg_a <= bus_wdata;
      if (evt_cap) reg_b <= cnt;
      else if (bus_wr && bus_addr == OFF_B && !ice) reg_b <= bus_wdata;
      if (csr_wr) ctl <= bus_wdata[4:0];
      if (evt_a)      tmr_out <= act_apply(tmr_out, sel_a);
      else if (evt_b) tmr_out <= act_apply(tmr_out, sel_b);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CNT: bus_rdata = cnt;
      OFF_A:   bus_rdata = reg_a;
      OFF_B:   bus_rdata = reg_b;
      default: bus_rdata[7:0] = {flag_q[2], flag_q[1], flag_q[0], ctl};
    endcase
  end
endmodule

// File: rtl/cmpcap_chk.sv
module cmpcap_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         bus_wr,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] reg_b,
  input logic [2:0]   flag_q,
  input logic [2:0]   arm_q,
  input logic         evt_ovf,
  input logic         evt_a,
  input logic         evt_cap,
  input logic [1:0]   sel_a,
  input logic         ice,
  input logic         tmr_out
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !(bus_wr && bus_addr == 2'd0)) |=> $stable(cnt));

  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> flag_q[0]);

  assert_drive_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_a && sel_a == 2'b10) |=> tmr_out);

  assert_drive_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_a && sel_a == 2'b01) |=> !tmr_out);

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cap |=> (flag_q[2] && reg_b == $past(cnt)));

  assert_b_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ice && !evt_cap) |=> $stable(reg_b));

  assert_armed_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[1]) |-> $past(arm_q[1]));

  assert_set_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(evt_a));
endmodule

bind cmpcap_timer cmpcap_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .cnt(cnt), .reg_b(reg_b), .flag_q(flag_q),
  .arm_q(arm_q), .evt_ovf(evt_ovf), .evt_a(evt_a), .evt_cap(evt_cap),
  .sel_a(sel_a), .ice(ice), .tmr_out(tmr_out)
);

// File: tb/tb_cmpcap_timer.sv
`timescale 1ns/1ps
module tb_cmpcap_timer;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         cap_in = 1'b0;
  logic         tmr_out, flag_ovf, flag_a, flag_b;

  always #2.5 clk = ~clk;

  cmpcap_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cap_in(cap_in), .tmr_out(tmr_out),
    .flag_ovf(flag_ovf), .flag_a(flag_a), .flag_b(flag_b)
  );

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t sbq[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  event  rd_ev;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected item and compares with the read data.
  always @(rd_ev) begin
    item_t it;
    if (sbq.size() == 0) chk("scoreboard empty", 8'h00, 8'h01);
    else begin
      it = sbq.pop_front();
      chk(it.tag, bus_rdata, it.exp);
    end
  end

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [W-1:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    sbq.push_back('{exp, tag});
    #1;
    ->rd_ev;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic step(int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic cap_set(logic v);
    @(negedge clk);
    cap_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, 8'h00, "R1 counter");
    rd(2'd1, 8'h00, "R1 reg A");
    rd(2'd2, 8'h00, "R1 reg B");
    rd(2'd3, 8'h00, "R1 csr");
    chk("R1 output", W'(tmr_out), 8'h00);
    chk("R1 flags", W'({flag_b, flag_a, flag_ovf}), 8'h00);

    // R4 compare A, drive high
    wr(2'd1, 8'h03);
    wr(2'd3, 8'h02);
    step(2);
    chk("R4 no early flag A", W'(flag_a), 8'h00);
    chk("R4 no early output", W'(tmr_out), 8'h00);
    step(1);
    chk("R4 flag A on match", W'(flag_a), 8'h01);
    chk("R4 drive high", W'(tmr_out), 8'h01);
    rd(2'd0, 8'h03, "R2 counter after 3 steps");
    repeat (3) @(negedge clk);
    rd(2'd0, 8'h03, "R2 hold without enable");

    // R8 zero write without prior read
    wr(2'd3, 8'h03);
    chk("R8 unarmed clear ignored", W'(flag_a), 8'h01);

    // R4 toggle
    wr(2'd0, 8'h00);
    step(3);
    chk("R4 toggle", W'(tmr_out), 8'h00);

    // R8 write 1 no effect, then armed clear
    wr(2'd3, 8'h43);
    chk("R8 write one keeps flag", W'(flag_a), 8'h01);
    rd(2'd3, 8'h43, "R3 csr layout");
    wr(2'd3, 8'h03);
    chk("R8 armed clear", W'(flag_a), 8'h00);
    rd(2'd3, 8'h03, "R8 csr after clear");

    // R3 wrap
    wr(2'd0, 8'hFE);
    step(1);
    chk("R3 no wrap at FF", W'(flag_ovf), 8'h00);
    step(1);
    chk("R3 wrap flag", W'(flag_ovf), 8'h01);
    rd(2'd0, 8'h00, "R3 counter wrapped");

    // R5 compare B
    wr(2'd2, 8'h05);
    wr(2'd3, 8'h08);
    wr(2'd0, 8'h04);
    step(1);
    chk("R5 flag B", W'(flag_b), 8'h01);
    chk("R5 B drive high", W'(tmr_out), 8'h01);

    // R5 same-step priority: A low wins over B high
    wr(2'd1, 8'h07);
    wr(2'd2, 8'h07);
    wr(2'd3, 8'h09);
    wr(2'd0, 8'h06);
    step(1);
    chk("R5 A wins", W'(tmr_out), 8'h00);
    rd(2'd3, 8'hE9, "R3 all flags set");
    wr(2'd3, 8'h10);
    chk("R8 all cleared", W'({flag_b, flag_a, flag_ovf}), 8'h00);
    rd(2'd3, 8'h10, "R3 capture enable");

    // R7 B write ignored in capture mode
    wr(2'd2, 8'h55);
    rd(2'd2, 8'h07, "R7 B write ignored");

    // R6 rising-edge capture with latency
    wr(2'd0, 8'h20);
    @(negedge clk);
    cap_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 no capture before 3 edges", W'(flag_b), 8'h00);
    @(negedge clk);
    chk("R6 flag B on capture", W'(flag_b), 8'h01);
    rd(2'd2, 8'h20, "R6 captured value");

    // R7 compare on B suppressed in capture mode
    rd(2'd3, 8'h90, "R6 csr after capture");
    wr(2'd3, 8'h18);
    chk("R8 flag B cleared", W'(flag_b), 8'h00);
    wr(2'd0, 8'h1F);
    step(1);
    chk("R7 no compare flag B", W'(flag_b), 8'h00);
    chk("R7 output untouched", W'(tmr_out), 8'h00);

    // R6 both-edge mode catches falling
    wr(2'd0, 8'h33);
    cap_set(1'b0);
    rd(2'd2, 8'h33, "R6 both edges falling");

    // R6 falling-only mode
    wr(2'd3, 8'h14);
    wr(2'd0, 8'h44);
    cap_set(1'b1);
    rd(2'd2, 8'h33, "R6 rise ignored in falling mode");
    cap_set(1'b0);
    rd(2'd2, 8'h44, "R6 falling capture");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule